// File: doc/BRIEF.md
# Multislope Runup Sequencer

This block drives the runup phase of a charge-balancing integrating converter. A system-clock divider produces a modulation tick. At the start of a runup and at every tick edge, the block samples a synchronized copy of the integrator's polarity comparator. That sample picks the reference current, positive or negative, that flows into the integrator for the whole of the next tick. There is no fixed switching pattern: only the comparator decides.

After a programmed number of ticks, the block sends all three current paths to ground: the signal input, the positive reference and the negative reference. It then holds the integrator for a fixed window. A start-of-conversion strobe lets an auxiliary converter read the residual voltage during that window. A done pulse publishes the total tick count and the number of ticks that carried the positive reference. The negative-reference count is the total minus that number. When the window ends, the next runup begins at once, with no discharge step.

A start input arms the first runup, so several units can be launched from one shared trigger.

Top module: `msr_runup_seq`

## Requirements
- R1: While reset is low at a clock edge, the block returns to idle. In idle, all three path selects, `soc` and `done` are 0, and both count outputs read 0.
- R2: In idle, the block stays idle until a clock edge samples `start` high. After that edge the input path is connected (`in_sel`=1).
- R3: During a runup, a tick edge falls every `DIV_CYC` clocks, counted from the edge that began the runup. The reference choice changes only at the runup's first edge and at tick edges, and it holds for the whole tick.
- R4: A sampled comparator value of 1 connects the positive reference (`pos_sel`=1, `neg_sel`=0). A value of 0 connects the negative reference (`pos_sel`=0, `neg_sel`=1). During a runup exactly one reference is connected.
- R5: The comparator passes through two flops before it is sampled. A level set at least three clock edges before a decision edge is used. A level that first appears after the edge immediately before the decision edge is not used.
- R6: `RUN_TICKS`×`DIV_CYC` clocks after a runup begins, all three path selects go to 0 and stay at 0 for `HOLD_CYC` clocks.
- R7: On the first hold cycle, `done` and `soc` are 1 for exactly one cycle. `tot_cnt` then reads `RUN_TICKS` and `pos_cnt` reads the number of ticks that carried the positive reference. Both hold their values until the next `done`.
- R8: When the hold ends, a new runup begins in the very next cycle, with a fresh comparator decision and the input path reconnected.
- R9: `start` is ignored during a runup or a hold, and the timing of the following done pulse is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Arms the first runup when the block is idle |
| cmp_in | input | 1 | Integrator polarity comparator, asynchronous |
| in_sel | output | 1 | 1: signal input to integrator, 0: to ground |
| pos_sel | output | 1 | 1: positive reference to integrator, 0: to ground |
| neg_sel | output | 1 | 1: negative reference to integrator, 0: to ground |
| soc | output | 1 | Start-of-conversion strobe for the residual converter |
| done | output | 1 | One-cycle pulse when new counts are valid |
| tot_cnt | output | $clog2(RUN_TICKS+1) | Ticks in the last runup |
| pos_cnt | output | $clog2(RUN_TICKS+1) | Positive-reference ticks in the last runup |

## Verification
If the tick or hold counters are corrupted, the `done` pulse arrives in the wrong cycle. That becomes visible within one runup-plus-hold period of the fault. If the polarity latch is wrong, or the comparator sampling is skewed, the wrong reference select appears in the same tick. It also shows up in a wrong `pos_cnt` at the end of that runup. Back-to-back runups with different comparator patterns expose counts that leak from one runup into the next. Comparator changes placed late, just before a tick edge, expose a synchronizer that is too short.

// File: rtl/msr_pkg.sv
// Shared types for the multislope runup sequencer.
package msr_pkg;

    // Operating phase of the sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_HOLD = 2'd2
    } phase_t;

endpackage

// File: rtl/msr_sync.sv
// Multi-flop synchronizer for the asynchronous comparator level.
// Assumes the input is a slow level; no pulse stretching is done.
module msr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];

    // R5: last stage is the previous value of the stage before it
    a_r5_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        chain[STAGES-1] == $past(chain[STAGES-2]));

endmodule

// File: rtl/msr_tick_gen.sv
// Modulation tick divider. Counts system clocks while run is high and
// emits a one-cycle tick every DIV_CYC clocks; clears whenever run is low,
// so a runup always starts with a full first tick. Assumes DIV_CYC >= 2.
module msr_tick_gen #(
    parameter int DIV_CYC = 333,
    localparam int DIV_W  = $clog2(DIV_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_CYC - 1);

    logic [DIV_W-1:0] div_cnt;

    // Free-run the divider during a runup, hold at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run)     div_cnt <= '0;
        else if (div_cnt == LAST) div_cnt <= '0;
        else                    div_cnt <= div_cnt + 1'b1;
    end

    assign tick = run && (div_cnt == LAST);

    // R3: divider never passes its last value
    a_r3_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= LAST);

    // R3: ticks are isolated single-cycle pulses
    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/msr_runup_seq.sv
// Runup sequencer for a charge-balancing integrating converter.
// Idle until start; then runs RUN_TICKS modulation ticks, steering the
// reference chosen by the synchronized comparator at each tick edge;
// then grounds all paths for HOLD_CYC clocks with a conversion strobe,
// and restarts. Assumes the analog side tolerates a one-clock select skew.
module msr_runup_seq
    import msr_pkg::*;
#(
    parameter int DIV_CYC   = 333,
    parameter int RUN_TICKS = 7500,
    parameter int HOLD_CYC  = 250,
    localparam int TICK_W   = $clog2(RUN_TICKS + 1),
    localparam int HOLD_W   = $clog2(HOLD_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmp_in,
    output logic              in_sel,
    output logic              pos_sel,
    output logic              neg_sel,
    output logic              soc,
    output logic              done,
    output logic [TICK_W-1:0] tot_cnt,
    output logic [TICK_W-1:0] pos_cnt
);

    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(RUN_TICKS - 1);
    localparam logic [TICK_W-1:0] ALL_TICKS = TICK_W'(RUN_TICKS);
    localparam logic [HOLD_W-1:0] LAST_HOLD = HOLD_W'(HOLD_CYC - 1);

    phase_t             ph;
    logic               cmp_s;
    logic               tick;
    logic               pol;
    logic [TICK_W-1:0]  tick_cnt;
    logic [TICK_W-1:0]  pos_acc;
    logic [HOLD_W-1:0]  hold_cnt;
    logic               done_q;
    logic               soc_q;
    logic [TICK_W-1:0]  tot_q;
    logic [TICK_W-1:0]  pos_q;
    logic               running;

    assign running = (ph == PH_RUN);

    msr_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (cmp_in),
        .d_out (cmp_s)
    );

    msr_tick_gen #(.DIV_CYC(DIV_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .tick  (tick)
    );

    // Phase sequencing, polarity latch, tick and positive-tick counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            pol      <= 1'b0;
            tick_cnt <= '0;
            pos_acc  <= '0;
            hold_cnt <= '0;
            done_q   <= 1'b0;
            soc_q    <= 1'b0;
            tot_q    <= '0;
            pos_q    <= '0;
        end else begin
            done_q <= 1'b0;
            soc_q  <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph       <= PH_RUN;
                        pol      <= cmp_s;
                        tick_cnt <= '0;
                        pos_acc  <= '0;
                    end
                end
                PH_RUN: begin
                    if (tick) begin
                        if (tick_cnt == LAST_TICK) begin
                            ph       <= PH_HOLD;
                            hold_cnt <= '0;
                            done_q   <= 1'b1;
                            soc_q    <= 1'b1;
                            tot_q    <= ALL_TICKS;
                            pos_q    <= pos_acc + {{(TICK_W-1){1'b0}}, pol};
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                            pos_acc  <= pos_acc + {{(TICK_W-1){1'b0}}, pol};
                            pol      <= cmp_s;
                        end
                    end
                end
                PH_HOLD: begin
                    if (hold_cnt == LAST_HOLD) begin
                        ph       <= PH_RUN;
                        pol      <= cmp_s;
                        tick_cnt <= '0;
                        pos_acc  <= '0;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Path selects: input and one reference in runup, all grounded otherwise
    always_comb begin
        in_sel  = running;
        pos_sel = running && pol;
        neg_sel = running && !pol;
    end

    assign soc     = soc_q;
    assign done    = done_q;
    assign tot_cnt = tot_q;
    assign pos_cnt = pos_q;

    // R4: one reference path exactly while the input is connected
    a_r4_one_ref: assert property (@(posedge clk) disable iff (!rst_n)
        in_sel |-> (pos_sel != neg_sel));

    // R3: reference choice only moves at a tick edge inside a runup
    a_r3_steady_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sel && $past(in_sel) && !$past(tick)) |-> $stable(pos_sel));

    // R6: tick counter stays within the programmed runup
    a_r6_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt < ALL_TICKS);

    // R6: a done pulse always lands in a grounded hold
    a_r6_done_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!in_sel && !pos_sel && !neg_sel));

    // R7: done is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: positive ticks never exceed the total
    a_r7_pos_le_tot: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pos_cnt <= tot_cnt));

endmodule

// File: tb/tb_msr_runup_seq.sv
// Bench for the runup sequencer: a vector table of comparator patterns
// walked back to back, then directed reset and idle checks.
module tb_msr_runup_seq;

    localparam int D = 8;
    localparam int N = 10;
    localparam int H = 5;
    localparam int W = $clog2(N + 1);

    typedef struct packed {
        logic [9:0] pat;     // comparator level for tick k at bit k
        logic [3:0] npos;    // expected positive ticks
        logic       glitch;  // flip comparator one clock before each tick edge
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{10'h000, 4'd0,  1'b0},
        '{10'h3FF, 4'd10, 1'b0},
        '{10'h155, 4'd5,  1'b0},
        '{10'h3E0, 4'd5,  1'b1},
        '{10'h201, 4'd2,  1'b0},
        '{10'h2C6, 4'd5,  1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_in = 1'b0;
    logic         in_sel, pos_sel, neg_sel, soc, done;
    logic [W-1:0] tot_cnt, pos_cnt;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    msr_runup_seq #(.DIV_CYC(D), .RUN_TICKS(N), .HOLD_CYC(H)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
        .in_sel(in_sel), .pos_sel(pos_sel), .neg_sel(neg_sel),
        .soc(soc), .done(done), .tot_cnt(tot_cnt), .pos_cnt(pos_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " in_sel"}, in_sel, 0);
        chk({tag, " pos_sel"}, pos_sel, 0);
        chk({tag, " neg_sel"}, neg_sel, 0);
        chk({tag, " done"}, done, 0);
        chk({tag, " soc"}, soc, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_idle("R1 reset");
        chk("R1 tot_cnt", tot_cnt, 0);
        chk("R1 pos_cnt", pos_cnt, 0);
        rst_n = 1'b1;
        // R2: no runup without start
        cmp_in = VECS[0].pat[0];
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk_idle("R2 idle before start");
        end
        start = 1'b1;
        // Vector walk: edge c counted from the start of each runup
        for (int v = 0; v < NV; v++) begin
            for (int c = 0; c < N * D + H; c++) begin
                @(posedge clk);
                @(negedge clk);
                if (v == 0 && c == 0) start = 1'b0;
                if (v == 2 && c == 20) start = 1'b1;   // R9 stray start
                if (v == 2 && c == 21) start = 1'b0;
                if (c < N * D) begin
                    int  k;
                    bit  b;
                    k = c / D;
                    b = VECS[v].pat[k];
                    if (v > 0 && c == 0) chk("R8 immediate restart", in_sel, 1);
                    chk("R2 input connected", in_sel, 1);
                    chk(VECS[v].glitch ? "R5 late change ignored" : "R3 tick steering",
                        pos_sel, b);
                    chk("R4 negative ref", neg_sel, !b);
                    chk("R9 no early done", done, 0);
                end else if (c == N * D) begin
                    chk("R6 hold input", in_sel, 0);
                    chk("R6 hold pos", pos_sel, 0);
                    chk("R6 hold neg", neg_sel, 0);
                    chk("R7 done pulse", done, 1);
                    chk("R7 soc pulse", soc, 1);
                    chk("R7 tot_cnt", tot_cnt, N);
                    chk("R7 pos_cnt", pos_cnt, VECS[v].npos);
                end else begin
                    chk_idle("R6 hold grounded");
                    chk("R7 pos_cnt held", pos_cnt, VECS[v].npos);
                end
                // Comparator drive for the coming decision edges
                for (int k = 1; k < N; k++) begin
                    if (c == k * D - 4) cmp_in = VECS[v].pat[k];
                    if (VECS[v].glitch && c == k * D - 1) cmp_in = !VECS[v].pat[k];
                end
                if (c == N * D + H - 4 && v + 1 < NV) cmp_in = VECS[v+1].pat[0];
            end
        end
        // R1: reset in the middle of a runup
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1 mid-run reset");
        chk("R1 tot_cnt cleared", tot_cnt, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk_idle("R2 idle after reset");
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule